// File: doc/BRIEF.md
# Fixed-Frame Serial Register Bank Slave

This block lets a host controller reach a bank of sixteen 16-bit control registers over a four-wire serial port. Every access is one frame of exactly 24 serial clocks, bounded by an active-low select. A frame either writes one register or reads one back. The frame is sent most significant bit first. Bit 23 is the direction flag, where 1 means read. Bits 20:17 carry the register address and bits 15:0 carry the data. Bits 22, 21 and 16 are spare and are ignored.

The serial lines are oversampled by the core clock, and edges are found by comparing each line with its value one clock earlier. The lines must already be synchronous to the core clock, and each SCLK phase must last at least two core clocks. Read data leaves on SCLK falling edges, so the host can sample it on rising edges. A separate output enable marks the cycles in which the slave drives its data line, so data-in and data-out can share one wire. A level input selects pins-only operation and holds every register at its default value while it is high.

Top module: `spi_regbank_slave`

## Requirements
- R1: After reset, register i (i = 0..15) holds the 16-bit value {i[3:0], 12'hA5C}, and sdo_oe is low.
- R2: In a frame with bit 23 = 0, the 16 data bits are written to the register selected by bits 20:17. The register changes in the core-clock cycle that follows the 24th SCLK rising edge, and no other register changes.
- R3: In a frame with bit 23 = 1, the addressed register is captured after the 8th rising edge (bit 16). Its bits leave MSB first on the falling edges that follow rising edges 8 through 23, so the host samples D15 to D0 on rising edges 9 through 24. sdo_oe rises together with D15.
- R4: If cs_n goes high before the 24th rising edge, the frame is dropped and no register changes.
- R5: In a write frame, SCLK edges after the 24th do not change any register. Once a frame has used its 24 clocks, nothing starts until cs_n has gone high and then low again.
- R6: In a read frame that is held beyond 24 clocks, sdo keeps driving D0 and sdo_oe stays high until cs_n goes high.
- R7: sdo_oe is low in every core-clock cycle after one in which cs_n was sampled high. It is also low throughout a write frame.
- R8: While pins_only is high, all registers are held at their R1 defaults. Write frames have no effect, and reads return the defaults. The defaults remain after pins_only falls.
- R9: Frame bits 22, 21 and 16 have no effect on which register is accessed or on the data written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins_only | input | 1 | High holds every register at its default value |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data to the host |
| sdo_oe | output | 1 | High while the slave drives sdo |
| regs_o | output | 256 | All registers flattened, register i in bits 16*i+15 : 16*i |

## Verification
An SCLK edge is seen one core clock after the bench drives it. A written register therefore appears in the cycle that follows the 24th rising edge. The bench moves its reference register array at the moment it raises that edge and compares every register at one nanosecond past each core-clock edge, so the model and the design line up exactly. Read bits are taken just before each host rising edge, several core clocks after the falling edge that launched them. The output-enable release is checked three core clocks after select goes high, and both abort and overrun frames are followed by a read-back.

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave #(
  parameter int NREG    = 16,
  parameter int DW      = 16,
  parameter int FRAME   = 24,
  parameter int AW      = $clog2(NREG),
  parameter logic [DW-AW-1:0] DEF_LOW = 12'hA5C
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pins_only,
  input  logic                 cs_n,
  input  logic                 sclk,
  input  logic                 sdi,
  output logic                 sdo,
  output logic                 sdo_oe,
  output logic [NREG*DW-1:0]   regs_o
);
  localparam int CW     = $clog2(FRAME + 1);
  localparam int DSTART = FRAME - DW;
  localparam int RD_CAP = FRAME - 1 - (DW + 1);

  function automatic logic [NREG*DW-1:0] defaults();
    logic [NREG*DW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*DW +: DW] = {AW'(i), DEF_LOW};
    return v;
  endfunction

  logic [NREG*DW-1:0] def_vec;
  assign def_vec = defaults();

  logic              sclk_q, cs_q, active, rd;
  logic [CW-1:0]     cnt;
  logic [FRAME-2:0]  sh;
  logic [DW-1:0]     rq;
  logic [DW-1:0]     regs [NREG];

  wire rise  = sclk & ~sclk_q;
  wire fall  = ~sclk & sclk_q;
  wire start = ~cs_n & cs_q;
  wire live  = active & ~cs_n;

  wire           last   = live & rise & (cnt == CW'(FRAME - 1));
  wire           wr_en  = last & ~sh[FRAME-2] & ~pins_only;
  wire [AW-1:0]  wr_adr = sh[DW+AW-1 -: AW];
  wire [DW-1:0]  wr_dat = {sh[DW-2:0], sdi};
  wire           cap    = live & rise & (cnt == CW'(DSTART - 1));
  wire           shout  = live & rd & fall & (cnt >= CW'(DSTART)) & (cnt <= CW'(FRAME - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
      sh     <= '0;
    end else if (cs_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (live && rise && cnt < CW'(FRAME)) begin
      cnt <= cnt + 1'b1;
      sh  <= {sh[FRAME-3:0], sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd     <= 1'b0;
      rq     <= '0;
      sdo    <= 1'b0;
      sdo_oe <= 1'b0;
    end else if (cs_n) begin
      rd     <= 1'b0;
      sdo_oe <= 1'b0;
    end else begin
      if (cap) begin
        rd <= sh[RD_CAP];
        rq <= regs[sh[AW-1:0]];
      end
      if (shout) begin
        sdo    <= rq[DW-1];
        rq     <= {rq[DW-2:0], 1'b0};
        sdo_oe <= 1'b1;
      end
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           regs[g] <= def_vec[g*DW +: DW];
      else if (pins_only)                   regs[g] <= def_vec[g*DW +: DW];
      else if (wr_en && wr_adr == AW'(g))   regs[g] <= wr_dat;
    end
    assign regs_o[g*DW +: DW] = regs[g];
  end
endmodule

module spi_regbank_chk #(
  parameter int W = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cs_n,
  input logic         pins_only,
  input logic         sdo_oe,
  input logic [W-1:0] regs_o,
  input logic [W-1:0] def_vec
);
  // R7
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !sdo_oe);

  // R8
  hold_defaults_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pins_only |=> (regs_o == def_vec));

  // R4
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && !pins_only) |=> $stable(regs_o));

  // R3
  oe_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe) |-> $past(!cs_n));
endmodule

bind spi_regbank_slave spi_regbank_chk #(.W(NREG*DW)) u_chk (.*);

// File: tb/tb_spi_regbank_slave.sv
module tb_spi_regbank_slave;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pins_only = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic sdo, sdo_oe;
  logic [255:0] regs_o;

  spi_regbank_slave dut (.*);

  always #2 clk = ~clk;

  int vecs = 0;
  int errs = 0;
  logic [15:0] m [16];
  bit cmp_on = 1'b0;
  int cs_hi_run = 0;

  function automatic logic [15:0] defv(int i);
    return {4'(i), 12'hA5C};
  endfunction

  function automatic logic [23:0] mk(bit r, logic [2:0] sp, logic [3:0] a, logic [15:0] d);
    return {r, sp[2:1], a, sp[0], d};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      bit bad = 1'b0;
      for (int i = 0; i < 16; i++)
        if (regs_o[i*16 +: 16] !== m[i]) begin
          bad = 1'b1;
          $display("FAIL R2 R4 R5 R8 reg %0d actual=%h expected=%h", i, regs_o[i*16 +: 16], m[i]);
        end
      vecs++;
      if (bad) errs++;
      cs_hi_run = cs_n ? cs_hi_run + 1 : 0;
      if (cs_hi_run >= 2) chk("R7 oe idle", 32'(sdo_oe), 32'd0);
    end
  end

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [23:0] w, int nclk, output logic [15:0] got);
    bit r = w[23];
    logic [15:0] exp;
    got = '0;
    exp = m[w[20:17]];
    cs_n = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nclk; i++) begin
      sdi = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(4);
      if (r && i >= 8 && i < 24) begin
        got[23-i] = sdo;
        chk("R3 oe", 32'(sdo_oe), 32'd1);
      end
      if (r && i >= 24) begin
        chk("R6 hold", 32'(sdo), 32'(exp[0]));
        chk("R6 oe", 32'(sdo_oe), 32'd1);
      end
      if (!r) chk("R7 oe write", 32'(sdo_oe), 32'd0);
      sclk = 1'b1;
      if (i == 23 && !r && !pins_only) m[w[20:17]] = w[15:0];
      wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    cs_n = 1'b1;
    wait_clk(3);
    chk("R7 oe release", 32'(sdo_oe), 32'd0);
    wait_clk(4);
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [15:0] exp);
    logic [15:0] g;
    frame(mk(1'b1, 3'b000, a, 16'h0), 24, g);
    chk(req, 32'(g), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [15:0] g;
    for (int i = 0; i < 16; i++) m[i] = defv(i);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);
    // R1 reset state
    for (int i = 0; i < 16; i++) chk("R1 default", 32'(regs_o[i*16 +: 16]), 32'(defv(i)));
    chk("R1 oe", 32'(sdo_oe), 32'd0);
    cmp_on = 1'b1;

    // R2 writes of several patterns, R3 read-back
    frame(mk(1'b0, 3'b000, 4'd3, 16'h1234), 24, g);
    frame(mk(1'b0, 3'b000, 4'd0, 16'hFFFF), 24, g);
    frame(mk(1'b0, 3'b000, 4'd15, 16'h8001), 24, g);
    rd_chk("R3 read r3", 4'd3, 16'h1234);
    rd_chk("R3 read r0", 4'd0, 16'hFFFF);
    rd_chk("R3 read r15", 4'd15, 16'h8001);
    rd_chk("R3 read default r9", 4'd9, defv(9));

    // R9 spare bits set
    frame(mk(1'b0, 3'b111, 4'd6, 16'h5A5A), 24, g);
    frame(mk(1'b1, 3'b111, 4'd6, 16'h0000), 24, g);
    chk("R9 spare bits", 32'(g), 32'h5A5A);

    // R4 abort at several points
    frame(mk(1'b0, 3'b000, 4'd7, 16'hDEAD), 20, g);
    frame(mk(1'b0, 3'b000, 4'd7, 16'hBEEF), 23, g);
    rd_chk("R4 abort", 4'd7, defv(7));

    // R5 write overrun
    frame(mk(1'b0, 3'b000, 4'd2, 16'hC3C3), 40, g);
    rd_chk("R5 overrun write", 4'd2, 16'hC3C3);
    rd_chk("R5 no extra write r0", 4'd0, 16'hFFFF);

    // R6 read overrun with D0 = 1 and D0 = 0
    frame(mk(1'b1, 3'b000, 4'd15, 16'h0), 30, g);
    chk("R6 data", 32'(g), 32'h8001);
    frame(mk(1'b1, 3'b000, 4'd3, 16'h0), 30, g);
    chk("R6 data", 32'(g), 32'h1234);

    // R8 pins-only hold
    pins_only = 1'b1;
    for (int i = 0; i < 16; i++) m[i] = defv(i);
    wait_clk(3);
    frame(mk(1'b0, 3'b000, 4'd4, 16'h7777), 24, g);
    rd_chk("R8 read default r3", 4'd3, defv(3));
    rd_chk("R8 write ignored r4", 4'd4, defv(4));
    pins_only = 1'b0;
    wait_clk(3);
    rd_chk("R8 after release r0", 4'd0, defv(0));
    frame(mk(1'b0, 3'b000, 4'd4, 16'h0F0F), 24, g);
    rd_chk("R2 write after release", 4'd4, 16'h0F0F);

    wait_clk(4);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule